// File: doc/BRIEF.md
# Reference-Counted Pad Clamp Sequencer

This block owns three isolation and power controls for a pad group: a core power-down flag, an early clamp and a main clamp. Any number of clients share the pads. Each client issues a one-cycle enable request when it needs the pads and a one-cycle disable request when it is done. A use count tracks the clients. Only the transition of the count from zero to nonzero releases the pads, and only the return to zero clamps them again. Releasing drops the main clamp first, then the early clamp, then core power-down. Clamping applies the same three controls in the opposite order.

Consecutive steps of either sequence are separated by a fixed number of clock cycles. By default this is derived from the clock frequency so that the gap is 100 microseconds. Requests that arrive during a sequence update the count at once but never cut the sequence short. When the sequence ends, the sequencer compares the pad state with the count and starts the opposite sequence if they disagree. A force-off input drains the count one step per cycle, so that exactly one clamp sequence results. A disable request with no users is reported on an error pulse and otherwise ignored.

Top module: `pad_clamp_seq`

## Requirements
- R1: While reset is applied and in the first cycle after it, `pwr_down_o`, `clamp_early_o` and `clamp_main_o` are 1, `use_cnt_o` is 0, and `busy_o` and `unbal_err_o` are 0.
- R2: An enable request alone (no disable, no force-off) raises `use_cnt_o` by one at the next clock edge. A release sequence starts only when the count was zero before the request. The main clamp clears at the clock edge after the count becomes 1.
- R3: A release sequence clears `clamp_main_o`, clears `clamp_early_o` exactly GAP_CYCLES cycles later, and clears `pwr_down_o` GAP_CYCLES cycles after that.
- R4: A clamp sequence starts when the sequencer is idle, the count is zero and the pads are released. It sets `pwr_down_o`, sets `clamp_early_o` GAP_CYCLES cycles later, and sets `clamp_main_o` GAP_CYCLES cycles after that.
- R5: By default GAP_CYCLES equals CLK_FREQ_HZ / 1,000,000 × GAP_US. With 50 MHz and 100 µs this is 5000 cycles.
- R6: A disable request alone while the count is zero pulses `unbal_err_o` for one cycle after the clock edge. The count and the three pad controls are left unchanged by it.
- R7: A disable request alone while the count is above one decrements the count and starts no sequence.
- R8: While `force_off_i` is high and the count is nonzero, the count falls by one per cycle, and `en_req_i` and `dis_req_i` are ignored. The drain ends in exactly one clamp sequence and raises no error.
- R9: Requests during a running sequence change the count immediately, and the sequence always completes. If the count and the pad state then disagree, the opposite sequence starts on the next cycle.
- R10: `busy_o` is high from the first step of a sequence until its last step, and the pad controls change only while a sequence runs. When `busy_o` falls, all three controls hold the same value.
- R11: Simultaneous enable and disable requests leave the count unchanged and raise no error. An enable request at the maximum count (2^CNT_W − 1) is ignored.
- R12: At most one pad control changes per cycle. A cleared `pwr_down_o` implies a cleared `clamp_early_o`, and a cleared `clamp_early_o` implies a cleared `clamp_main_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_req_i | input | 1 | One-cycle enable request from a client |
| dis_req_i | input | 1 | One-cycle disable request from a client |
| force_off_i | input | 1 | Drain the use count to zero while high |
| pwr_down_o | output | 1 | Core power-down control, 1 = powered down |
| clamp_early_o | output | 1 | Early clamp control, 1 = clamped |
| clamp_main_o | output | 1 | Main clamp control, 1 = clamped |
| busy_o | output | 1 | A release or clamp sequence is running |
| unbal_err_o | output | 1 | One-cycle pulse on a disable with zero users |
| use_cnt_o | output | CNT_W | Current use count |

## Verification
Several properties are checked on every cycle:
- the nesting of the three controls and the single-control-per-cycle rule;
- the exact cycle spacing between steps, measured by a counter in the checker;
- controls changing only inside a busy window, and agreeing when busy falls;
- count steps of at most one and the force-off decrement;
- the error pulse occurring only at a zero count.

Other behaviours come only from the bench's scenarios against its timeline model:
- only the first enable and the last disable launch a sequence;
- a request that arrives mid-sequence produces the opposite sequence afterwards;
- force-off yields exactly one clamp sequence;
- the count saturates at its maximum;
- the default gap comes to 5000 cycles at 50 MHz.

// File: rtl/pad_clamp_pkg.sv
package pad_clamp_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_REL_1,
    PH_REL_2,
    PH_AST_1,
    PH_AST_2
  } phase_e;

  typedef struct packed {
    logic pwr_down;
    logic clamp_early;
    logic clamp_main;
  } pad_ctl_t;

  localparam pad_ctl_t PAD_CTL_SAFE = '{pwr_down: 1'b1, clamp_early: 1'b1, clamp_main: 1'b1};

endpackage

// File: rtl/pad_use_counter.sv
module pad_use_counter #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_req_i,
  input  logic             dis_req_i,
  input  logic             force_off_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             nz_o,
  output logic             err_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             err_q;
  logic             inc, dec;

  always_comb begin
    dec   = force_off_i | (dis_req_i & ~en_req_i);
    inc   = en_req_i & ~dis_req_i & ~force_off_i;
    cnt_d = cnt_q;
    if (dec && cnt_q != '0)         cnt_d = cnt_q - 1'b1;
    else if (inc && cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      err_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      // unbalanced disable: a client request, not a force-off drain
      err_q <= dis_req_i & ~en_req_i & ~force_off_i & (cnt_q == '0);
    end
  end

  assign cnt_o = cnt_q;
  assign nz_o  = (cnt_q != '0);
  assign err_o = err_q;
endmodule

// File: rtl/pad_gap_timer.sv
module pad_gap_timer #(
  parameter int unsigned GAP_CYCLES = 5000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic done_o
);
  generate
    if (GAP_CYCLES <= 1) begin : g_single
      assign done_o = 1'b1;
    end else begin : g_count
      localparam int unsigned TW = $clog2(GAP_CYCLES);
      localparam logic [TW-1:0] RELOAD = TW'(GAP_CYCLES - 1);
      logic [TW-1:0] tmr_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)            tmr_q <= '0;
        else if (load_i)        tmr_q <= RELOAD;
        else if (tmr_q != '0)   tmr_q <= tmr_q - 1'b1;
      end

      assign done_o = (tmr_q == '0);
    end
  endgenerate
endmodule

// File: rtl/pad_clamp_fsm.sv
module pad_clamp_fsm
  import pad_clamp_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     users_i,
  input  logic     gap_done_i,
  output logic     gap_load_o,
  output pad_ctl_t ctl_o,
  output logic     busy_o
);
  phase_e   ph_q;
  pad_ctl_t ctl_q;
  logic     start_rel, start_ast;

  always_comb begin
    start_rel  = (ph_q == PH_IDLE) &&  users_i &&  ctl_q.pwr_down;
    start_ast  = (ph_q == PH_IDLE) && !users_i && !ctl_q.pwr_down;
    gap_load_o = start_rel || start_ast ||
                 (gap_done_i && (ph_q == PH_REL_1 || ph_q == PH_AST_1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_IDLE;
      ctl_q <= PAD_CTL_SAFE;
    end else begin
      unique case (ph_q)
        PH_IDLE: begin
          if (start_rel) begin
            ctl_q.clamp_main <= 1'b0;
            ph_q             <= PH_REL_1;
          end else if (start_ast) begin
            ctl_q.pwr_down <= 1'b1;
            ph_q           <= PH_AST_1;
          end
        end
        PH_REL_1: if (gap_done_i) begin
          ctl_q.clamp_early <= 1'b0;
          ph_q              <= PH_REL_2;
        end
        PH_REL_2: if (gap_done_i) begin
          ctl_q.pwr_down <= 1'b0;
          ph_q           <= PH_IDLE;
        end
        PH_AST_1: if (gap_done_i) begin
          ctl_q.clamp_early <= 1'b1;
          ph_q              <= PH_AST_2;
        end
        PH_AST_2: if (gap_done_i) begin
          ctl_q.clamp_main <= 1'b1;
          ph_q             <= PH_IDLE;
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign ctl_o  = ctl_q;
  assign busy_o = (ph_q != PH_IDLE);
endmodule

// File: rtl/pad_clamp_seq.sv
module pad_clamp_seq
  import pad_clamp_pkg::*;
#(
  parameter int unsigned CLK_FREQ_HZ = 50_000_000,
  parameter int unsigned GAP_US      = 100,
  parameter int unsigned GAP_CYCLES  = CLK_FREQ_HZ / 1_000_000 * GAP_US,
  parameter int unsigned CNT_W       = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_req_i,
  input  logic             dis_req_i,
  input  logic             force_off_i,
  output logic             pwr_down_o,
  output logic             clamp_early_o,
  output logic             clamp_main_o,
  output logic             busy_o,
  output logic             unbal_err_o,
  output logic [CNT_W-1:0] use_cnt_o
);
  logic     users, gap_load, gap_done;
  pad_ctl_t ctl;

  pad_use_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_req_i    (en_req_i),
    .dis_req_i   (dis_req_i),
    .force_off_i (force_off_i),
    .cnt_o       (use_cnt_o),
    .nz_o        (users),
    .err_o       (unbal_err_o)
  );

  pad_gap_timer #(.GAP_CYCLES(GAP_CYCLES)) u_gap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (gap_load),
    .done_o (gap_done)
  );

  pad_clamp_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .users_i    (users),
    .gap_done_i (gap_done),
    .gap_load_o (gap_load),
    .ctl_o      (ctl),
    .busy_o     (busy_o)
  );

  assign pwr_down_o    = ctl.pwr_down;
  assign clamp_early_o = ctl.clamp_early;
  assign clamp_main_o  = ctl.clamp_main;
endmodule

// File: rtl/pad_clamp_seq_chk.sv
module pad_clamp_seq_chk #(
  parameter int unsigned GAP_CYCLES = 5000,
  parameter int unsigned CNT_W      = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_req_i,
  input logic             dis_req_i,
  input logic             force_off_i,
  input logic             pwr_down_o,
  input logic             clamp_early_o,
  input logic             clamp_main_o,
  input logic             busy_o,
  input logic             unbal_err_o,
  input logic [CNT_W-1:0] use_cnt_o
);
  logic [2:0]  ctl, prev_q;
  logic        chg;
  logic [31:0] gap_q;

  assign ctl = {pwr_down_o, clamp_early_o, clamp_main_o};
  assign chg = (ctl != prev_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 3'b111;
      gap_q  <= '0;
    end else begin
      prev_q <= ctl;
      if (chg)                gap_q <= 32'd1;
      else if (gap_q != '1)   gap_q <= gap_q + 32'd1;
    end
  end

  assert_nesting_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pwr_down_o |-> !clamp_early_o) and (!clamp_early_o |-> !clamp_main_o));

  assert_one_change_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(ctl ^ prev_q) <= 1);

  assert_step_gap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg && $past(busy_o) |-> gap_q == GAP_CYCLES);

  assert_change_in_seq_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg |-> busy_o || $fell(busy_o));

  assert_end_uniform_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (pwr_down_o == clamp_early_o) && (clamp_early_o == clamp_main_o));

  assert_err_at_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unbal_err_o |-> use_cnt_o == '0);

  assert_cnt_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    use_cnt_o != $past(use_cnt_o) |->
      (use_cnt_o == $past(use_cnt_o) + 1'b1) || (use_cnt_o + 1'b1 == $past(use_cnt_o)));

  assert_force_drain_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_off_i && use_cnt_o != '0 |=> use_cnt_o + 1'b1 == $past(use_cnt_o));

  assert_force_no_err_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_off_i |=> !unbal_err_o);
endmodule

bind pad_clamp_seq pad_clamp_seq_chk #(.GAP_CYCLES(GAP_CYCLES), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/tb_pad_clamp_seq.sv
module tb_pad_clamp_seq;
  localparam int GAP   = 6;
  localparam int CW    = 3;
  localparam int CMAX  = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, dis = 1'b0, frc = 1'b0;
  logic pd, ce, cm, busy, err;
  logic [CW-1:0] cnt;

  logic d_en = 1'b0;
  logic d_pd, d_ce, d_cm, d_busy, d_err;
  logic [3:0] d_cnt;

  always #10 clk = ~clk;

  pad_clamp_seq #(.GAP_CYCLES(GAP), .CNT_W(CW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .en_req_i(en), .dis_req_i(dis), .force_off_i(frc),
    .pwr_down_o(pd), .clamp_early_o(ce), .clamp_main_o(cm), .busy_o(busy),
    .unbal_err_o(err), .use_cnt_o(cnt));

  pad_clamp_seq dut_def (
    .clk_i(clk), .rst_ni(rst_n), .en_req_i(d_en), .dis_req_i(1'b0), .force_off_i(1'b0),
    .pwr_down_o(d_pd), .clamp_early_o(d_ce), .clamp_main_o(d_cm), .busy_o(d_busy),
    .unbal_err_o(d_err), .use_cnt_o(d_cnt));

  int checks = 0, errors = 0;
  bit done = 0;

  // timeline model
  int  m_cnt = 0, n = 0, t0 = 0;
  bit  m_pd = 1, m_ce = 1, m_cm = 1, m_busy = 0, m_err = 0, m_rel = 0;
  int  busy_rises = 0, err_seen = 0, pd_low_seen = 0;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, n);
    end
  endtask

  task automatic model_step(bit e, bit d, bit f);
    int c = m_cnt;
    m_err = d && !e && !f && (c == 0);
    if (!m_busy) begin
      if (c > 0 && m_pd) begin
        m_cm = 0; m_busy = 1; m_rel = 1; t0 = n;
      end else if (c == 0 && !m_pd) begin
        m_pd = 1; m_busy = 1; m_rel = 0; t0 = n;
      end
    end else if (n - t0 == GAP) begin
      m_ce = !m_rel;
    end else if (n - t0 == 2 * GAP) begin
      if (m_rel) m_pd = 0; else m_cm = 1;
      m_busy = 0;
    end
    if (f || (d && !e)) begin
      if (c > 0) m_cnt = c - 1;
    end else if (e && !d) begin
      if (c < CMAX) m_cnt = c + 1;
    end
    n++;
  endtask

  task automatic cyc(bit e = 0, bit d = 0, bit f = 0);
    bit b_prev = busy;
    en = e; dis = d; frc = f;
    model_step(e, d, f);
    @(negedge clk);
    en = 0; dis = 0; frc = 0;
    chk("R2 count", cnt, m_cnt);
    chk("R3/R4 controls", {pd, ce, cm}, {m_pd, m_ce, m_cm});
    chk("R10 busy", busy, m_busy);
    chk("R6 error", err, m_err);
    if (busy && !b_prev) busy_rises++;
    if (err) err_seen++;
    if (!pd) pd_low_seen++;
  endtask

  task automatic idle(int k);
    for (int i = 0; i < k; i++) cyc();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state held during reset
    chk("R1 ctl in reset", {pd, ce, cm}, 3'b111);
    chk("R1 cnt in reset", cnt, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ctl", {pd, ce, cm}, 3'b111);
    chk("R1 busy/err", {busy, err}, 0);
    chk("R1 cnt", cnt, 0);

    // R2/R3: first enable releases
    cyc(1); idle(2 * GAP + 3);
    chk("R3 released", {pd, ce, cm}, 3'b000);
    // R2: further enables only count
    busy_rises = 0;
    cyc(1); cyc(1); idle(3);
    chk("R2 cnt=3", cnt, 3);
    chk("R2 no sequence", busy_rises, 0);
    // R7: decrement with users remaining
    cyc(0, 1); idle(3);
    chk("R7 cnt=2", cnt, 2);
    chk("R7 no sequence", busy_rises, 0);
    chk("R7 ctl", {pd, ce, cm}, 3'b000);
    // R4: last disable clamps
    cyc(0, 1); cyc(0, 1); idle(2 * GAP + 3);
    chk("R4 clamped", {pd, ce, cm}, 3'b111);
    chk("R4 one sequence", busy_rises, 1);
    // R6: unbalanced disable
    err_seen = 0;
    cyc(0, 1);
    chk("R6 err pulse", err, 1);
    cyc();
    chk("R6 err single", err_seen, 1);
    chk("R6 cnt/ctl kept", {cnt, pd, ce, cm}, {3'd0, 3'b111});
    // R11: simultaneous requests
    err_seen = 0; busy_rises = 0;
    cyc(1, 1); idle(3);
    chk("R11 simul cnt", cnt, 0);
    chk("R11 simul no err/seq", err_seen + busy_rises, 0);
    // R9: disable mid-release
    busy_rises = 0; pd_low_seen = 0;
    cyc(1); idle(3); cyc(0, 1); idle(5 * GAP);
    chk("R9 release completed", pd_low_seen > 0, 1);
    chk("R9 two sequences", busy_rises, 2);
    chk("R9 final clamped", {pd, ce, cm}, 3'b111);
    // R8: force-off drain
    cyc(1); cyc(1); cyc(1); idle(2 * GAP + 3);
    busy_rises = 0; err_seen = 0;
    for (int i = 0; i < 2 * GAP + 8; i++) cyc(i % 2, 1, 1);
    idle(3);
    chk("R8 cnt drained", cnt, 0);
    chk("R8 one clamp seq", busy_rises, 1);
    chk("R8 no err", err_seen, 0);
    chk("R8 clamped", {pd, ce, cm}, 3'b111);
    // R11: saturation
    for (int i = 0; i < CMAX + 3; i++) cyc(1);
    idle(2 * GAP + 2);
    chk("R11 saturate", cnt, CMAX);
    for (int i = 0; i < CMAX; i++) cyc(0, 1);
    idle(2 * GAP + 3);
    chk("R11 back to zero", {cnt, pd, ce, cm}, {3'd0, 3'b111});

    // R5: default gap
    begin
      int k = 0;
      d_en = 1; @(negedge clk); d_en = 0;
      while (d_cm && k < 10) begin @(negedge clk); k++; end
      k = 0;
      while (d_ce && k < 6000) begin @(negedge clk); k++; end
      chk("R5 default gap", k, 5000);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule